// File: doc/BRIEF.md
# Nibble/Byte Clocked Serial Shifter

This block moves one data word over a three-wire synchronous serial link: a data input, a data output and a bidirectional shift clock. One shift register holds the word. The host loads it before a transfer and reads it back afterwards. Each transfer moves either a 4-bit nibble or an 8-bit byte. The host picks the length with a control bit before each start, and the most significant bit of the active window goes first.

As clock master the block makes the shift clock from an instruction-cycle strobe. The clock is low for 32 strobes and then high for 32 strobes, so each bit takes 64 instruction cycles. As slave it takes the clock from the pin. It passes that clock through a two-stage synchroniser and detects its edges on the system clock. In both modes the input bit is sampled at the rising clock edge, and the output changes only after a falling edge. When the last bit has been sampled, a completion flag is set and a one-cycle interrupt request is raised. After reset the serial function is off and the three pins carry the host's plain port values.

Top module: `nibyte_sio`

## Requirements
- R1: After reset the serial function is disabled, `pin_out` equals `port_dout`, `done` and `irq` are 0 and `rd_data` is 0.
- R2: While the enable bit is 0, `pin_out` follows `port_dout` combinationally. A start request written while disabled launches no transfer, so `done` stays 0.
- R3: A control write (`wr_sel`=1) decodes `wr_data` bit 0 as enable, bit 1 as byte length (1 = 8 bits, 0 = 4 bits), bit 2 as master and bit 3 as start. While enabled, pin bit 0 (data in) is driven high (released), pin bit 1 carries the serial output and pin bit 2 the shift clock, which idles high.
- R4: In master mode the shift clock on `pin_out[2]` stays low for exactly HALF_TICKS strobes of `tcyc_stb` and then high for HALF_TICKS strobes. `done` rises 2·HALF_TICKS·N strobes after the edge that takes the start write, where N is the transfer length. Without a strobe the clock holds its level.
- R5: The data input is sampled at each rising shift-clock edge. After a byte transfer `rd_data` holds the eight sampled bits, first sampled in bit 7.
- R6: The serial output presents the top bit of the active window from the start of the transfer and changes only after a falling shift-clock edge. The bits leave most significant first.
- R7: In 4-bit mode exactly four bits move through `rd_data[3:0]`, and `rd_data[7:4]` keeps the value that was loaded.
- R8: In slave mode the external clock on `sck_pin` sets the bit timing through a two-stage synchroniser, and `pin_out[2]` stays high (released).
- R9: At the edge that samples the last bit, `done` becomes 1 and stays 1, and `irq` pulses high for one cycle. A new start clears `done`.
- R10: While a transfer is active, data writes and control writes (including start) are ignored. The word, the mode and the bit count are left intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tcyc_stb | input | 1 | One-cycle strobe per instruction cycle, master clock base |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | 0 = load data word, 1 = control write |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Shift register contents (received word) |
| done | output | 1 | Completion flag (buffer full/empty) |
| irq | output | 1 | One-cycle interrupt request on completion |
| port_dout | input | 3 | Plain port values used while serial is disabled |
| si_pin | input | 1 | Serial data input pin level |
| sck_pin | input | 1 | External shift clock pin level |
| pin_out | output | 3 | Pin drive: bit 0 data in, bit 1 data out, bit 2 shift clock |

## Verification
In master mode each shift-clock edge comes exactly HALF_TICKS strobes after the previous one. `done` and `irq` are checked at the negative edge that follows the 2·HALF_TICKS·N-th clock after the start write. With the strobe running every other cycle, a window of two cycles is accepted. The serial output is compared with a queue of expected bits. Each bit is taken from the negative edge just before the observed rising clock edge, because the final rise also shifts the register at that edge. In slave mode the block responds about three system clocks after each bench clock edge: two synchroniser stages and the edge detector. The bench therefore holds each clock half for six cycles and waits for `done` before it compares `rd_data`.

// File: rtl/nibyte_sio_pkg.sv
package nibyte_sio_pkg;

    localparam int SIO_W     = 8;
    localparam int SIO_SHORT = 4;
    localparam int CNT_W     = $clog2(SIO_W) + 1;
    localparam int NPINS     = 3;
    localparam int PIN_SI    = 0;
    localparam int PIN_SO    = 1;
    localparam int PIN_SCK   = 2;

    typedef logic [SIO_W-1:0] word_t;
    typedef logic [CNT_W-1:0] cnt_t;

    // control write layout, bit 3 down to bit 0
    typedef struct packed {
        logic start;
        logic master;
        logic len8;
        logic enable;
    } ctl_t;

    typedef struct packed {
        logic master;
        logic len8;
        logic enable;
    } mode_t;

    function automatic cnt_t xfer_len(input logic len8);
        return len8 ? cnt_t'(SIO_W) : cnt_t'(SIO_SHORT);
    endfunction

    function automatic word_t shift_in(input word_t d, input logic len8, input logic b);
        word_t r;
        if (len8) r = {d[SIO_W-2:0], b};
        else      r = {d[SIO_W-1:SIO_SHORT], d[SIO_SHORT-2:0], b};
        return r;
    endfunction

    function automatic logic out_bit(input word_t d, input logic len8);
        return len8 ? d[SIO_W-1] : d[SIO_SHORT-1];
    endfunction

endpackage

// File: rtl/nibyte_sio_sckgen.sv
module nibyte_sio_sckgen #(
    parameter int HALF_TICKS = 32,
    parameter int SYNC_N     = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic run,
    input  logic master,
    input  logic ext_sck,
    output logic sck_line,
    output logic rise,
    output logic fall
);
    localparam int HW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;

    logic [HW-1:0]   half_cnt;
    logic            sck_q;
    logic [SYNC_N:0] sync_q;   // [0] first stage, [SYNC_N] previous value
    logic            wrap;
    logic            m_rise, m_fall, s_rise, s_fall;

    assign wrap   = tick && (half_cnt == HW'(HALF_TICKS - 1));
    assign m_rise = run && master && wrap && !sck_q;
    assign m_fall = run && master && wrap && sck_q;
    assign s_rise = run && !master && sync_q[SYNC_N-1] && !sync_q[SYNC_N];
    assign s_fall = run && !master && !sync_q[SYNC_N-1] && sync_q[SYNC_N];

    assign rise     = m_rise | s_rise;
    assign fall     = m_fall | s_fall;
    assign sck_line = sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_cnt <= '0;
            sck_q    <= 1'b1;
            sync_q   <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_N-1:0], ext_sck};
            if (run && master) begin
                if (tick) begin
                    if (wrap) begin
                        half_cnt <= '0;
                        sck_q    <= !sck_q;
                    end else begin
                        half_cnt <= half_cnt + HW'(1);
                    end
                end
            end else begin
                half_cnt <= '0;
                sck_q    <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/nibyte_sio_shifter.sv
module nibyte_sio_shifter
    import nibyte_sio_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t load_data,
    input  logic  clear,
    input  logic  len8,
    input  logic  rise,
    input  logic  fall,
    input  logic  si,
    output word_t data,
    output logic  so,
    output logic  finish,
    output cnt_t  bit_cnt
);
    word_t sr_q;
    logic  cap_q;
    cnt_t  cnt_q;

    assign finish  = rise && ((cnt_q + cnt_t'(1)) == xfer_len(len8));
    assign data    = sr_q;
    assign so      = out_bit(sr_q, len8);
    assign bit_cnt = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            cap_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            if (load) sr_q <= load_data;
            if (clear) begin
                cnt_q <= '0;
            end else if (rise) begin
                cap_q <= si;
                cnt_q <= cnt_q + cnt_t'(1);
                if (finish) sr_q <= shift_in(sr_q, len8, si);
            end else if (fall && (cnt_q != '0)) begin
                sr_q <= shift_in(sr_q, len8, cap_q);
            end
        end
    end
endmodule

// File: rtl/nibyte_sio_pinmux.sv
module nibyte_sio_pinmux
    import nibyte_sio_pkg::*;
(
    input  logic             enable,
    input  logic             master,
    input  logic             sck_line,
    input  logic             so,
    input  logic [NPINS-1:0] port_dout,
    output logic [NPINS-1:0] pin_out
);
    logic [NPINS-1:0] ser_drive;

    always_comb begin
        ser_drive          = '1;
        ser_drive[PIN_SI]  = 1'b1;
        ser_drive[PIN_SO]  = so;
        ser_drive[PIN_SCK] = master ? sck_line : 1'b1;
    end

    assign pin_out = enable ? ser_drive : port_dout;
endmodule

// File: rtl/nibyte_sio.sv
module nibyte_sio
    import nibyte_sio_pkg::*;
#(
    parameter int HALF_TICKS = 32,
    parameter int SYNC_N     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tcyc_stb,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [SIO_W-1:0] wr_data,
    output logic [SIO_W-1:0] rd_data,
    output logic             done,
    output logic             irq,
    input  logic [NPINS-1:0] port_dout,
    input  logic             si_pin,
    input  logic             sck_pin,
    output logic [NPINS-1:0] pin_out
);
    mode_t mode_q;
    logic  busy_q, done_q, irq_q;
    ctl_t  wctl;
    logic  ctl_wr, dat_wr, start;
    logic  sck_line, sck_rise, sck_fall, finish, so;
    word_t sr_data;
    cnt_t  shift_cnt;

    assign wctl   = ctl_t'(wr_data[3:0]);
    // R10: host writes are accepted only while idle
    assign ctl_wr = wr_en && wr_sel && !busy_q;
    assign dat_wr = wr_en && !wr_sel && !busy_q;
    // R2: start needs the enable bit of the same write
    assign start  = ctl_wr && wctl.start && wctl.enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (ctl_wr) mode_q <= mode_t'({wctl.master, wctl.len8, wctl.enable});
            if (start) begin
                busy_q <= 1'b1;
                done_q <= 1'b0;          // R9
            end else if (finish) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                irq_q  <= 1'b1;
            end
        end
    end

    nibyte_sio_sckgen #(.HALF_TICKS(HALF_TICKS), .SYNC_N(SYNC_N)) u_sck (
        .clk      (clk),
        .rst      (rst),
        .tick     (tcyc_stb),
        .run      (busy_q),
        .master   (mode_q.master),
        .ext_sck  (sck_pin),
        .sck_line (sck_line),
        .rise     (sck_rise),
        .fall     (sck_fall)
    );

    nibyte_sio_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (dat_wr),
        .load_data (wr_data),
        .clear     (start),
        .len8      (mode_q.len8),
        .rise      (sck_rise),
        .fall      (sck_fall),
        .si        (si_pin),
        .data      (sr_data),
        .so        (so),
        .finish    (finish),
        .bit_cnt   (shift_cnt)
    );

    nibyte_sio_pinmux u_mux (
        .enable    (mode_q.enable),
        .master    (mode_q.master),
        .sck_line  (sck_line),
        .so        (so),
        .port_dout (port_dout),
        .pin_out   (pin_out)
    );

    assign rd_data = sr_data;
    assign done    = done_q;
    assign irq     = irq_q;
endmodule

// File: rtl/nibyte_sio_chk.sv
module nibyte_sio_chk
    import nibyte_sio_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             wr_en,
    input logic             busy,
    input logic             en,
    input logic             master,
    input logic             len8,
    input logic             sck_rise,
    input logic             sck_fall,
    input logic             finish,
    input logic             done,
    input logic             irq,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] port_dout,
    input word_t            rd_data,
    input cnt_t             bit_cnt
);
    // R2
    port_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> (pin_out == port_dout));

    // R4
    sck_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && master && !tick) |=> $stable(pin_out[PIN_SCK]));

    // R6
    so_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !sck_rise && !sck_fall) |=> $stable(pin_out[PIN_SO]));

    // R9
    done_set_chk: assert property (@(posedge clk) disable iff (rst)
        finish |=> (done && irq && !busy));

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R10
    busy_write_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en && !sck_rise && !sck_fall) |=> $stable(rd_data));

    // R7
    len_bound_chk: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= xfer_len(len8));

    // R8
    slave_sck_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !master) |-> pin_out[PIN_SCK]);
endmodule

bind nibyte_sio nibyte_sio_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tcyc_stb),
    .wr_en     (wr_en),
    .busy      (busy_q),
    .en        (mode_q.enable),
    .master    (mode_q.master),
    .len8      (mode_q.len8),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .finish    (finish),
    .done      (done_q),
    .irq       (irq_q),
    .pin_out   (pin_out),
    .port_dout (port_dout),
    .rd_data   (sr_data),
    .bit_cnt   (shift_cnt)
);

// File: tb/nibyte_sio_bench.sv
module nibyte_sio_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 32;
    localparam int SL_HALF    = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tcyc_stb;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] port_dout = 3'b101;
    logic       si_bit = 1'b1;
    logic       sck_drv = 1'b1;
    wire  [7:0] rd_data;
    wire        done, irq;
    wire  [2:0] pin_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    nibyte_sio #(.HALF_TICKS(HALF)) u_nibyte_sio (
        .clk(clk), .rst(rst), .tcyc_stb(tcyc_stb), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_data(rd_data), .done(done), .irq(irq),
        .port_dout(port_dout), .si_pin(si_bit), .sck_pin(sck_drv), .pin_out(pin_out)
    );

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit stb_alt = 1'b0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) tcyc_stb <= stb_alt ? ~tcyc_stb : 1'b1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: pops expected SO bits at each observed SCK rise
    bit         mon_en = 1'b0;
    bit         mstr = 1'b0;
    bit         chk_w = 1'b0;
    logic [7:0] si_pat = 8'h00;
    int         si_idx = -1;
    int         low_len = 0;
    logic       prev_line = 1'b1;
    logic       so_prev = 1'b1;
    bit         so_q[$];
    wire        line = mstr ? pin_out[2] : sck_drv;

    always @(negedge clk) begin
        bit e;
        if (mon_en) begin
            if (prev_line && !line) begin
                low_len = 1;
                if (si_idx >= 0) begin
                    si_bit = si_pat[si_idx];
                    si_idx--;
                end
            end else if (!line) begin
                low_len++;
            end
            if (!prev_line && line) begin
                if (so_q.size() == 0) begin
                    check(1'b0, "R6 SCK rise with no bit expected", 1, 0);
                end else begin
                    e = so_q.pop_front();
                    check(so_prev == e, "R6 serial output bit", so_prev, e);
                end
                if (chk_w) check(low_len == HALF, "R4 SCK low width", low_len, HALF);
                if (!mstr) check(pin_out[2] == 1'b1, "R8 SCK pin released", pin_out[2], 1);
            end
        end
        prev_line = line;
        so_prev   = pin_out[1];
    end

    task automatic wr(input bit sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_xfer(input bit m, input bit l8, input logic [7:0] tx, input logic [7:0] si,
                            input int lo, input int hi, input bit poke);
        int len;
        int t0;
        int k;
        bit seen;
        logic [7:0] exp_rd;
        len = l8 ? 8 : 4;
        wr(1'b0, tx);
        for (int i = len - 1; i >= 0; i--) so_q.push_back(tx[i]);
        si_pat = si; si_idx = len - 1; mstr = m;
        chk_w = (lo == hi) && (lo != 0);
        mon_en = 1'b1;
        wr(1'b1, {4'b0000, 1'b1, m, l8, 1'b1});
        t0 = cyc;
        check(done == 1'b0, "R9 start clears done", done, 0);
        if (!m) begin
            for (int b = 0; b < len; b++) begin
                repeat (SL_HALF) @(posedge clk);
                #1 sck_drv = 1'b0;
                repeat (SL_HALF) @(posedge clk);
                #1 sck_drv = 1'b1;
            end
        end
        if (poke) begin
            repeat (100) @(negedge clk);
            wr(1'b0, 8'h00);
            wr(1'b1, 8'h0F);
        end
        seen = 1'b0; k = 0;
        while (!seen && k < 6000) begin
            @(negedge clk);
            if (done) seen = 1'b1;
            k++;
        end
        check(seen, "R9 completion flag set", seen, 1);
        if (lo != 0)
            check((cyc - t0 >= lo) && (cyc - t0 <= hi), "R4 transfer duration", cyc - t0, lo);
        check(irq == 1'b1, "R9 irq raised at completion", irq, 1);
        exp_rd = l8 ? si : {tx[7:4], si[3:0]};
        if (l8) check(rd_data == exp_rd, "R5 received byte", rd_data, exp_rd);
        else    check(rd_data == exp_rd, "R7 received nibble, upper kept", rd_data, exp_rd);
        if (poke) check(rd_data == exp_rd, "R10 writes during transfer ignored", rd_data, exp_rd);
        @(negedge clk);
        check(irq == 1'b0, "R9 irq lasts one cycle", irq, 0);
        check(done == 1'b1, "R9 done flag held", done, 1);
        check(so_q.size() == 0, "R6 all bits shifted out", so_q.size(), 0);
        so_q.delete();
        mon_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(pin_out == 3'b101, "R1 pins follow port after reset", pin_out, 3'b101);
        check(done == 1'b0, "R1 done clear after reset", done, 0);
        check(irq == 1'b0, "R1 irq clear after reset", irq, 0);
        check(rd_data == 8'h00, "R1 data clear after reset", rd_data, 0);
        // R2
        port_dout = 3'b010;
        @(negedge clk);
        check(pin_out == 3'b010, "R2 pins track port values", pin_out, 3'b010);
        wr(1'b1, 8'h08);
        repeat (150) @(negedge clk);
        check(done == 1'b0, "R2 start ignored while disabled", done, 0);
        check(pin_out == port_dout, "R2 pins still port after start", pin_out, port_dout);
        // R3
        wr(1'b1, 8'h01);
        @(negedge clk);
        check(pin_out[0] == 1'b1, "R3 data-in pin released", pin_out[0], 1);
        check(pin_out[2] == 1'b1, "R3 SCK idles high", pin_out[2], 1);
        wr(1'b1, 8'h07);
        @(negedge clk);
        check(pin_out[2] == 1'b1, "R3 master SCK idles high", pin_out[2], 1);

        run_xfer(1'b1, 1'b1, 8'hA5, 8'h3C, 2*HALF*8, 2*HALF*8, 1'b0);
        run_xfer(1'b1, 1'b0, 8'hB6, 8'h09, 2*HALF*4, 2*HALF*4, 1'b0);
        run_xfer(1'b0, 1'b1, 8'h5A, 8'hC3, 0, 0, 1'b0);
        run_xfer(1'b0, 1'b0, 8'hE1, 8'h0A, 0, 0, 1'b0);
        run_xfer(1'b1, 1'b1, 8'h96, 8'h69, 2*HALF*8, 2*HALF*8, 1'b1);
        stb_alt = 1'b1;
        run_xfer(1'b1, 1'b0, 8'h37, 8'h05, 4*HALF*4 - 1, 4*HALF*4, 1'b0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule